// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM with Pipelined Read

This block is a small clocked single-port memory. Each word holds four byte lanes, and every lane carries one parity bit. Two address strobes open an access cycle. The processor strobe always opens a read. The controller strobe opens either a read or a write, depending on the write enables present on the same edge.

After either strobe has opened a session on a selected device, the edges that follow without a strobe keep working on the held address. Each such edge either writes the lanes the enables pick or reads that address again. Read data passes through one output register. The output enable is not clocked: it gates the output drivers directly, and the block also gates them off internally during any cycle that writes.

The bidirectional data bus is split into an input path and an output path. A valid flag marks when the output path would drive the bus. When the flag is low, the bus is high-impedance and the data outputs read as zero.

Top module: `sram_bytewr`

## Requirements
- R1: With `wr_all_n` low on an edge that writes, all four lanes and all four parity bits take the new value, whatever `wr_lane_en_n` and `wr_lane_n` are.
- R2: With `wr_all_n` and `wr_lane_en_n` both high, no lane is written and the cycle is a read.
- R3: With `wr_all_n` high and `wr_lane_en_n` low, lane i is written only when `wr_lane_n[i]` is low. Lane i covers data bits 8i+7 down to 8i and parity bit i.
- R4: With `wr_all_n` high, `wr_lane_en_n` low and every `wr_lane_n` bit high, nothing is written. The cycle acts as a read, so the addressed word is driven in the following cycle.
- R5: An edge with `cpu_adr_n` low and `cs_n` low starts a read, and it writes nothing whatever the write enables say.
- R6: A write happens only in two cases. The first is an edge with `ctl_adr_n` low and `cs_n` low. The second is an edge with no strobe inside a session opened by an earlier strobe with `cs_n` low, and that write goes to the held address. A strobe edge with `cs_n` high ends the session, and later strobe-free edges write nothing.
- R7: When both strobes are low on the same edge, the edge behaves as a processor-strobe edge, so it is a read and nothing is written.
- R8: Read data for the address registered on edge k appears on `rdata` and `rpar` after edge k+1. After edge k itself, `out_valid` still reflects the cycle before.
- R9: `out_valid` is low at once whenever `out_en_n` is high, with no clock needed. It is also low during any cycle whose inputs cause a write on the coming edge, and in the cycle after a deselecting strobe.
- R10: After reset, `out_valid` is low and no session is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low, sampled on strobe edges |
| cpu_adr_n | input | 1 | Processor address strobe, active low, always a read |
| ctl_adr_n | input | 1 | Controller address strobe, active low |
| wr_all_n | input | 1 | Global write, active low, writes every lane |
| wr_lane_en_n | input | 1 | Enables the per-lane write selects, active low |
| wr_lane_n | input | 4 | Per-lane write selects, active low, bit i is lane i |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data, lane i in bits 8i+7:8i |
| wpar | input | 4 | Write parity, bit i for lane i |
| rdata | output | 32 | Registered read data, zero when not driven |
| rpar | output | 4 | Registered read parity, zero when not driven |
| out_valid | output | 1 | High when the data bus is driven, low means high-impedance |

## Verification
The hardest situation to reach is a write taken on a strobe-free edge. It needs a session that a processor-strobe read opened on the edge before. The stimulus must also pass through a deselecting strobe, so that the same enables then prove they do nothing.

The bench builds these orderings with a cycle-accurate model of the session state. On every cycle it works out which lanes will be written, updates a reference array, and checks that the bus is released on each write cycle. Lane-select patterns are applied over a known base word, so that each lane's merge is visible on read-back.

// File: rtl/sram_bytewr_pkg.sv
// Package: shared types for the byte-lane SRAM.
// Assumes: nothing; it holds only type declarations.
package sram_bytewr_pkg;

    // Kind of access that the coming clock edge performs.
    typedef enum logic [1:0] {
        CYC_NONE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2,
        CYC_DESEL = 2'd3
    } cyc_kind_e;

endpackage

// File: rtl/sbw_lane_decode.sv
// Module: turns the global, lane-enable and per-lane write inputs into a lane mask.
// Assumes: all inputs are active low, and the mask says nothing about whether the edge may write.
module sbw_lane_decode #(
    parameter int LANES = 4
) (
    input  logic             wr_all_n,
    input  logic             wr_lane_en_n,
    input  logic [LANES-1:0] wr_lane_n,
    output logic [LANES-1:0] lane_mask
);

    // The global write wins; otherwise the per-lane selects count only when enabled.
    always_comb begin
        if (!wr_all_n) begin
            lane_mask = '1;
        end else if (!wr_lane_en_n) begin
            lane_mask = ~wr_lane_n;
        end else begin
            lane_mask = '0;
        end
    end

endmodule

// File: rtl/sbw_cycle_ctrl.sv
// Module: classifies each edge as read, write, deselect or idle, and holds the session address.
// Assumes: chip select is sampled only on strobe edges, and the processor strobe outranks the controller strobe.
module sbw_cycle_ctrl
    import sram_bytewr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              cpu_adr_n,
    input  logic              ctl_adr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_mask,
    output logic [LANES-1:0]  wr_mask,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_active,
    output logic              rd_pend,
    output logic              sess
);

    logic              cpu_hit;
    logic              ctl_hit;
    logic              any_lane;
    logic              sess_q;
    logic              rd_pend_q;
    logic [ADDR_W-1:0] addr_q;
    cyc_kind_e         kind;

    assign cpu_hit  = !cpu_adr_n;
    assign ctl_hit  = !ctl_adr_n && cpu_adr_n;
    assign any_lane = |lane_mask;

    // Decide what the coming edge does from the strobes, the select and the session.
    always_comb begin
        if (cpu_hit) begin
            kind = cs_n ? CYC_DESEL : CYC_READ;
        end else if (ctl_hit) begin
            if (cs_n) begin
                kind = CYC_DESEL;
            end else begin
                kind = any_lane ? CYC_WRITE : CYC_READ;
            end
        end else if (sess_q) begin
            kind = any_lane ? CYC_WRITE : CYC_READ;
        end else begin
            kind = CYC_NONE;
        end
    end

    // Pass the lane mask only on an edge that really writes.
    always_comb begin
        wr_mask = (kind == CYC_WRITE) ? lane_mask : '0;
    end

    // A controller-strobe write uses the new address; a session write uses the held one.
    assign wr_addr   = ctl_hit ? addr : addr_q;
    assign wr_active = (kind == CYC_WRITE);

    // Track the session, the held address and whether a read is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sess_q    <= 1'b0;
            rd_pend_q <= 1'b0;
            addr_q    <= '0;
        end else begin
            if (cpu_hit || ctl_hit) begin
                sess_q <= !cs_n;
                if (!cs_n) begin
                    addr_q <= addr;
                end
            end
            rd_pend_q <= (kind == CYC_READ);
        end
    end

    assign rd_addr = addr_q;
    assign rd_pend = rd_pend_q;
    assign sess    = sess_q;

endmodule

// File: rtl/sbw_lane_array.sv
// Module: storage, one array per byte lane, each entry holding the data byte and its parity bit.
// Assumes: one write port and one asynchronous read port; contents are not reset.
module sbw_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [LANES-1:0]        wpar,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic [LANES-1:0]        rd_par
);

    localparam int DEPTH   = 1 << ADDR_W;
    localparam int ENTRY_W = LANE_W + 1;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [ENTRY_W-1:0] mem [DEPTH];

        // Store this lane's byte and parity when the lane's mask bit is set.
        always_ff @(posedge clk) begin
            if (wr_mask[l]) begin
                mem[wr_addr] <= {wpar[l], wdata[l*LANE_W +: LANE_W]};
            end
        end

        // Present this lane's entry at the read address.
        assign rd_data[l*LANE_W +: LANE_W] = mem[rd_addr][LANE_W-1:0];
        assign rd_par[l]                   = mem[rd_addr][LANE_W];
    end

endmodule

// File: rtl/sbw_out_stage.sv
// Module: the pipeline output register, and the gating that stands in for the bus drivers.
// Assumes: the output enable is asynchronous, and write cycles mask it internally.
module sbw_out_stage #(
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_pend,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [LANES-1:0]  rd_par,
    input  logic              out_en_n,
    input  logic              wr_active,
    output logic [DATA_W-1:0] rdata,
    output logic [LANES-1:0]  rpar,
    output logic              out_valid,
    output logic              pipe_vld
);

    logic [DATA_W-1:0] dout_q;
    logic [LANES-1:0]  pout_q;
    logic              vld_q;

    // Capture the word that a pending read fetches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
            pout_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= rd_pend;
            if (rd_pend) begin
                dout_q <= rd_data;
                pout_q <= rd_par;
            end
        end
    end

    // The drivers turn on only for registered read data, with the output enabled and no write under way.
    assign out_valid = vld_q && !out_en_n && !wr_active;
    assign rdata     = out_valid ? dout_q : '0;
    assign rpar      = out_valid ? pout_q : '0;
    assign pipe_vld  = vld_q;

endmodule

// File: rtl/sram_bytewr.sv
// Module: top level of the byte-lane SRAM with pipelined read and an asynchronous output enable.
// Assumes: the bus is split into in and out paths, with out_valid standing for the high-Z control.
module sram_bytewr #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    cpu_adr_n,
    input  logic                    ctl_adr_n,
    input  logic                    wr_all_n,
    input  logic                    wr_lane_en_n,
    input  logic [LANES-1:0]        wr_lane_n,
    input  logic                    out_en_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [LANES-1:0]        wpar,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic [LANES-1:0]        rpar,
    output logic                    out_valid
);

    localparam int DATA_W = LANES * LANE_W;

    logic [LANES-1:0]  lane_mask;
    logic [LANES-1:0]  wr_mask;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_active;
    logic              rd_pend;
    logic              sess;
    logic [DATA_W-1:0] rd_data;
    logic [LANES-1:0]  rd_par;
    logic              pipe_vld;

    sbw_lane_decode #(.LANES(LANES)) u_dec (
        .wr_all_n     (wr_all_n),
        .wr_lane_en_n (wr_lane_en_n),
        .wr_lane_n    (wr_lane_n),
        .lane_mask    (lane_mask)
    );

    sbw_cycle_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .cpu_adr_n (cpu_adr_n),
        .ctl_adr_n (ctl_adr_n),
        .addr      (addr),
        .lane_mask (lane_mask),
        .wr_mask   (wr_mask),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .wr_active (wr_active),
        .rd_pend   (rd_pend),
        .sess      (sess)
    );

    sbw_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk     (clk),
        .wr_mask (wr_mask),
        .wr_addr (wr_addr),
        .wdata   (wdata),
        .wpar    (wpar),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .rd_par  (rd_par)
    );

    sbw_out_stage #(.DATA_W(DATA_W), .LANES(LANES)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_pend   (rd_pend),
        .rd_data   (rd_data),
        .rd_par    (rd_par),
        .out_en_n  (out_en_n),
        .wr_active (wr_active),
        .rdata     (rdata),
        .rpar      (rpar),
        .out_valid (out_valid),
        .pipe_vld  (pipe_vld)
    );

endmodule

// File: rtl/sram_bytewr_chk.sv
// Module: property checker for the byte-lane SRAM, bound into every instance of the top.
// Assumes: it sees the control signals that the cycle controller and the output stage drive.
module sram_bytewr_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             cpu_adr_n,
    input logic             ctl_adr_n,
    input logic             wr_all_n,
    input logic             out_en_n,
    input logic             out_valid,
    input logic [LANES-1:0] wr_mask,
    input logic             rd_pend,
    input logic             sess,
    input logic             pipe_vld
);

    // R9
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !out_valid);

    // R9
    wr_hides_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_mask) |-> !out_valid);

    // R5
    cpu_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_adr_n |-> (wr_mask == '0));

    // R6
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_adr_n && ctl_adr_n && !sess) |-> (wr_mask == '0));

    // R1
    all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_all_n && !ctl_adr_n && cpu_adr_n && !cs_n) |-> (wr_mask == '1));

    // R8
    pipe_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_vld |-> $past(rd_pend));

endmodule

bind sram_bytewr sram_bytewr_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .cpu_adr_n (cpu_adr_n),
    .ctl_adr_n (ctl_adr_n),
    .wr_all_n  (wr_all_n),
    .out_en_n  (out_en_n),
    .out_valid (out_valid),
    .wr_mask   (wr_mask),
    .rd_pend   (rd_pend),
    .sess      (sess),
    .pipe_vld  (pipe_vld)
);

// File: tb/sram_bytewr_tb.sv
// Bench: directed scenarios against a cycle-level reference model of the byte-lane SRAM.
module sram_bytewr_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        cpu_adr_n = 1'b1;
    logic        ctl_adr_n = 1'b1;
    logic        wr_all_n = 1'b1;
    logic        wr_lane_en_n = 1'b1;
    logic [3:0]  wr_lane_n = 4'hF;
    logic        out_en_n = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  wpar = '0;
    logic [31:0] rdata;
    logic [3:0]  rpar;
    logic        out_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] ref_d [64];
    logic [3:0]  ref_p [64];
    bit          m_sess = 1'b0;
    logic [5:0]  m_addr = '0;

    always #2 clk = ~clk;

    sram_bytewr u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .cpu_adr_n    (cpu_adr_n),
        .ctl_adr_n    (ctl_adr_n),
        .wr_all_n     (wr_all_n),
        .wr_lane_en_n (wr_lane_en_n),
        .wr_lane_n    (wr_lane_n),
        .out_en_n     (out_en_n),
        .addr         (addr),
        .wdata        (wdata),
        .wpar         (wpar),
        .rdata        (rdata),
        .rpar         (rpar),
        .out_valid    (out_valid)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle, model it, check the bus release on writes, then move past the edge.
    task automatic cyc(input logic cpu_n, input logic ctl_n, input logic sel_n,
                       input logic gw_n, input logic bwe_n, input logic [3:0] bw_n,
                       input logic [5:0] a, input logic [31:0] d, input logic [3:0] p);
        logic [3:0] mask;
        logic [3:0] eff;
        logic [5:0] wa;
        @(negedge clk);
        cpu_adr_n = cpu_n; ctl_adr_n = ctl_n; cs_n = sel_n; wr_all_n = gw_n;
        wr_lane_en_n = bwe_n; wr_lane_n = bw_n; addr = a; wdata = d; wpar = p;
        mask = !gw_n ? 4'hF : (!bwe_n ? ~bw_n : 4'h0);
        eff = 4'h0;
        wa = m_addr;
        if (!cpu_n) begin
            m_sess = !sel_n;
            if (!sel_n) m_addr = a;
        end else if (!ctl_n) begin
            m_sess = !sel_n;
            if (!sel_n) begin
                m_addr = a;
                eff = mask;
                wa = a;
            end
        end else if (m_sess) begin
            eff = mask;
        end
        #1;
        if (eff != 4'h0) check("R9 write releases bus", {63'd0, out_valid}, 64'd0);
        @(posedge clk);
        for (int l = 0; l < 4; l++) begin
            if (eff[l]) begin
                ref_d[wa][l*8 +: 8] = d[l*8 +: 8];
                ref_p[wa][l] = p[l];
            end
        end
        #1;
    endtask

    task automatic idle_cyc();
        cyc(1, 1, 0, 1, 1, 4'hF, 6'd0, 32'd0, 4'd0);
    endtask

    task automatic desel_cyc();
        cyc(1, 0, 1, 1, 1, 4'hF, 6'd0, 32'd0, 4'd0);
    endtask

    // Open a read with the processor strobe, then compare the pipelined word with the model.
    task automatic read_check(input logic [5:0] a, input string req);
        cyc(0, 1, 0, 1, 1, 4'hF, a, 32'd0, 4'd0);
        idle_cyc();
        check({req, " valid"}, {63'd0, out_valid}, 64'd1);
        check({req, " data"}, {28'd0, rpar, rdata}, {28'd0, ref_p[a], ref_d[a]});
        desel_cyc();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset valid", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle_cyc();
        check("R10 no session after reset", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_full_write();
        cyc(1, 0, 0, 0, 0, 4'b1010, 6'd3, 32'hDEADBEEF, 4'hA);
        cyc(1, 0, 0, 0, 1, 4'hF, 6'd4, 32'h01234567, 4'h5);
        desel_cyc();
        read_check(6'd3, "R1");
        read_check(6'd4, "R1 lanes ignored");
    endtask

    task automatic t_lane_write();
        logic [3:0] pats [4] = '{4'b1110, 4'b0101, 4'b1011, 4'b0000};
        for (int i = 0; i < 4; i++) begin
            cyc(1, 0, 0, 0, 1, 4'hF, 6'd10, 32'h11223344, 4'h0);
            cyc(1, 0, 0, 1, 0, pats[i], 6'd10, 32'hA5C3E7F1 ^ (32'(i) << 4), 4'hF);
            desel_cyc();
            read_check(6'd10, "R3");
        end
    endtask

    task automatic t_no_write_reads();
        cyc(1, 0, 0, 0, 1, 4'hF, 6'd20, 32'hCAFEF00D, 4'h3);
        desel_cyc();
        cyc(1, 0, 0, 1, 1, 4'h0, 6'd20, 32'hFFFFFFFF, 4'hF);
        idle_cyc();
        check("R2 read data", {28'd0, rpar, rdata}, {32'd3, 32'hCAFEF00D});
        desel_cyc();
        cyc(1, 0, 0, 1, 0, 4'hF, 6'd20, 32'h0, 4'h0);
        check("R4 no data yet", {63'd0, out_valid}, 64'd0);
        idle_cyc();
        check("R4 reads next cycle", {28'd0, rpar, rdata}, {32'd3, 32'hCAFEF00D});
        desel_cyc();
    endtask

    task automatic t_cpu_read();
        cyc(0, 1, 0, 0, 0, 4'h0, 6'd20, 32'h0BADBAD0, 4'h9);
        check("R8 latency", {63'd0, out_valid}, 64'd0);
        idle_cyc();
        check("R5 old data", {28'd0, rpar, rdata}, {32'd3, 32'hCAFEF00D});
        desel_cyc();
        cyc(0, 0, 0, 0, 0, 4'h0, 6'd20, 32'h77777777, 4'h7);
        desel_cyc();
        read_check(6'd20, "R7");
    endtask

    task automatic t_session();
        cyc(0, 1, 0, 1, 1, 4'hF, 6'd30, 32'd0, 4'd0);
        cyc(1, 1, 0, 0, 1, 4'hF, 6'd31, 32'h5A5A1234, 4'hC);
        desel_cyc();
        read_check(6'd30, "R6 session write");
        cyc(1, 1, 0, 0, 1, 4'hF, 6'd30, 32'hEEEEEEEE, 4'h1);
        read_check(6'd30, "R6 no session");
    endtask

    task automatic t_oe();
        cyc(0, 1, 0, 1, 1, 4'hF, 6'd3, 32'd0, 4'd0);
        idle_cyc();
        check("R9 oe low drives", {63'd0, out_valid}, 64'd1);
        out_en_n = 1'b1;
        #0.5;
        check("R9 oe high no clock", {63'd0, out_valid}, 64'd0);
        out_en_n = 1'b0;
        #0.5;
        check("R9 oe back", {63'd0, out_valid}, 64'd1);
        desel_cyc();
        idle_cyc();
        check("R9 deselected", {63'd0, out_valid}, 64'd0);
    endtask

    initial begin
        t_reset();
        t_full_write();
        t_lane_write();
        t_no_write_reads();
        t_cpu_read();
        t_session();
        t_oe();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule